// File: doc/BRIEF.md
# Vector Length State Registers

This block keeps the vector-length configuration of a core: a maximum vector length, the current vector length, a sub-vector length, and three element offsets (source, destination and sub-vector destination). There are three independent copies of this state, one for each privilege level (machine, supervisor, user), and the current privilege input selects which copy the CSR port reads and writes.

Software reaches the state through a small CSR port with a combinational read. Written values are treated as "length minus one" and clamped: the maximum length against a fixed ceiling, the current length against the maximum, and the sub-vector length to a small range. A packed state word reports all fields at once and, when written, restores all of them in one cycle. When a trap is taken, the packed word of the active bank is copied into a save register belonging to the privilege level that takes the trap. These save registers can also be read and written through the CSR port.

The block holds no sequencing of its own. Every CSR write and trap capture completes on the clock edge on which it is presented.

Top module: `vlen_csr_top`

## Requirements
- R1: A write of value v to address 0 sets the selected bank's maximum length to v+1, capped at 64. Address 0 reads back the maximum length itself, not minus one.
- R2: A write of value v to address 1 sets the selected bank's current length to min(maximum length, v+1). Address 1 reads back the current length itself.
- R3: A write of value v to address 2 sets the sub-vector length: 1 when v is 0, 4 when v is 4 or more, otherwise v. Address 2 reads back the sub-vector length.
- R4: Address 3 reads the packed state. Bits 5:0 hold current length minus one, bits 11:6 maximum length minus one, bits 17:12 the source offset, bits 23:18 the destination offset, bits 25:24 sub-vector length minus one, and bits 27:26 the sub-vector offset. Upper bits are zero, and a length of zero reads as 0 in its field.
- R5: A write to address 3 applies the maximum length field first (field+1), then current length = min(new maximum, field+1), and sub-vector length = field+1. Source and destination offsets are limited to the new current length minus one, and the sub-vector offset to the new sub-vector length minus one.
- R6: After reset every bank has maximum length 0, current length 0, sub-vector length 1 and all offsets 0. Both save registers are 0.
- R7: When trap_valid is high, the packed state of the bank chosen by priv_lvl is stored into the machine save register (trap_priv = 3) or the supervisor save register (trap_priv = 1). For any other trap_priv value, neither save register changes.
- R8: priv_lvl 3 selects the machine bank, 1 the supervisor bank, and 0 or 2 the user bank. Writes through one bank leave the other banks unchanged.
- R9: Addresses 6 to 15 are not implemented. A write to them changes nothing, and a read of them returns zero.
- R10: Address 4 is the machine save register and address 5 the supervisor save register. Each stores the low 28 bits of a write and reads them back zero-extended. If a trap capture and a CSR write hit the same save register in one cycle, the capture wins.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| priv_lvl | input | 2 | Current privilege level; selects the bank |
| csr_we | input | 1 | CSR write strobe |
| csr_addr | input | 4 | CSR address |
| csr_wdata | input | 32 | CSR write data |
| csr_rdata | output | 32 | CSR read data, combinational from csr_addr |
| trap_valid | input | 1 | A trap is taken this cycle |
| trap_priv | input | 2 | Privilege level that takes the trap |

## Verification
The length writes are driven with values below, at and far above the caps, including the all-ones word. This separates a correct minus-one encoding and clamp from off-by-one errors and from wrap-around of v+1. Packed writes use fields whose offsets exceed the new length, and the maximum and current length fields are chosen so that clamping against the old maximum instead of the new one gives a different read-back. Accesses are spread across all four privilege encodings, so that a bank-select or cross-bank write fault shows up in another bank's read-back. The traps are aimed at the machine level, the supervisor level and a non-saving level, and one trap coincides with a CSR write to the same save register to expose the priority.

// File: rtl/vlen_pkg.sv
package vlen_pkg;
    localparam int VL_MAX  = 64;
    localparam int FW      = $clog2(VL_MAX);
    localparam int LW      = FW + 1;
    localparam int SW      = 2;
    localparam int P_VL    = 0;
    localparam int P_MVL   = FW;
    localparam int P_SRC   = 2 * FW;
    localparam int P_DST   = 3 * FW;
    localparam int P_SUB   = 4 * FW;
    localparam int P_DSV   = 4 * FW + SW;
    localparam int PACK_W  = 4 * FW + 2 * SW;
    localparam int NBANK   = 3;

    typedef enum logic [1:0] {
        BANK_U = 2'd0,
        BANK_S = 2'd1,
        BANK_M = 2'd2
    } bank_e;

    typedef enum logic [2:0] {
        WK_NONE,
        WK_MAXLEN,
        WK_CURLEN,
        WK_SUBLEN,
        WK_PACKED
    } wkind_e;

    typedef struct packed {
        logic [LW-1:0] maxlen;
        logic [LW-1:0] curlen;
        logic [SW:0]   sublen;
        logic [FW-1:0] src_off;
        logic [FW-1:0] dst_off;
        logic [SW-1:0] sub_off;
    } vlen_state_t;

    function automatic logic [PACK_W-1:0] pack_state(input vlen_state_t s);
        logic [PACK_W-1:0] r;
        logic [LW-1:0]     cm1;
        logic [LW-1:0]     mm1;
        logic [SW:0]       sm1;
        cm1 = s.curlen - 1'b1;
        mm1 = s.maxlen - 1'b1;
        sm1 = s.sublen - 1'b1;
        r = '0;
        r[P_VL  +: FW] = (s.curlen == '0) ? '0 : cm1[FW-1:0];
        r[P_MVL +: FW] = (s.maxlen == '0) ? '0 : mm1[FW-1:0];
        r[P_SRC +: FW] = s.src_off;
        r[P_DST +: FW] = s.dst_off;
        r[P_SUB +: SW] = (s.sublen == '0) ? '0 : sm1[SW-1:0];
        r[P_DSV +: SW] = s.sub_off;
        return r;
    endfunction
endpackage

// File: rtl/vlen_bank.sv
module vlen_bank
    import vlen_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  wkind_e           wr_kind,
    input  logic [XLEN-1:0]  wr_data,
    output vlen_state_t      st_o
);
    localparam logic [LW-1:0] CAP      = LW'(VL_MAX);
    localparam logic [SW:0]   SUB_MAX  = (SW + 1)'(1 << SW);

    vlen_state_t st_q;
    vlen_state_t st_d;

    logic [FW-1:0] f_cur, f_max, f_src, f_dst;
    logic [SW-1:0] f_sub, f_dsv;
    logic [LW-1:0] p_max, p_cur, p_lim;
    logic [SW:0]   p_sub, p_slim;

    always_comb begin
        f_cur = wr_data[P_VL  +: FW];
        f_max = wr_data[P_MVL +: FW];
        f_src = wr_data[P_SRC +: FW];
        f_dst = wr_data[P_DST +: FW];
        f_sub = wr_data[P_SUB +: SW];
        f_dsv = wr_data[P_DSV +: SW];
        p_max = {1'b0, f_max} + 1'b1;
        p_cur = ({1'b0, f_cur} >= p_max) ? p_max : ({1'b0, f_cur} + 1'b1);
        p_lim = p_cur - 1'b1;
        p_sub = {1'b0, f_sub} + 1'b1;
        p_slim = p_sub - 1'b1;
    end

    always_comb begin
        st_d = st_q;
        unique case (wr_kind)
            WK_MAXLEN: st_d.maxlen = (wr_data >= XLEN'(CAP)) ? CAP
                                     : (wr_data[LW-1:0] + 1'b1);
            WK_CURLEN: st_d.curlen = (wr_data >= XLEN'(st_q.maxlen)) ? st_q.maxlen
                                     : (wr_data[LW-1:0] + 1'b1);
            WK_SUBLEN: begin
                if (wr_data == '0)
                    st_d.sublen = (SW + 1)'(1);
                else if (wr_data >= XLEN'(SUB_MAX))
                    st_d.sublen = SUB_MAX;
                else
                    st_d.sublen = wr_data[SW:0];
            end
            WK_PACKED: begin
                st_d.maxlen  = p_max;
                st_d.curlen  = p_cur;
                st_d.sublen  = p_sub;
                st_d.src_off = ({1'b0, f_src} > p_lim) ? p_lim[FW-1:0] : f_src;
                st_d.dst_off = ({1'b0, f_dst} > p_lim) ? p_lim[FW-1:0] : f_dst;
                st_d.sub_off = ({1'b0, f_dsv} > p_slim) ? p_slim[SW-1:0] : f_dsv;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q        <= '0;
            st_q.sublen <= (SW + 1)'(1);
        end else begin
            st_q <= st_d;
        end
    end

    assign st_o = st_q;
endmodule

// File: rtl/vlen_save_reg.sv
module vlen_save_reg
    import vlen_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cap_en,
    input  logic [PACK_W-1:0] cap_val,
    input  logic              wr_en,
    input  logic [XLEN-1:0]   wr_val,
    output logic [PACK_W-1:0] q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            q <= '0;
        else if (cap_en)
            q <= cap_val;
        else if (wr_en)
            q <= wr_val[PACK_W-1:0];
    end
endmodule

// File: rtl/vlen_csr_top.sv
module vlen_csr_top
    import vlen_pkg::*;
#(
    parameter int XLEN   = 32,
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        priv_lvl,
    input  logic              csr_we,
    input  logic [ADDR_W-1:0] csr_addr,
    input  logic [XLEN-1:0]   csr_wdata,
    output logic [XLEN-1:0]   csr_rdata,
    input  logic              trap_valid,
    input  logic [1:0]        trap_priv
);
    localparam logic [ADDR_W-1:0] A_MAX   = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] A_CUR   = ADDR_W'(1);
    localparam logic [ADDR_W-1:0] A_SUB   = ADDR_W'(2);
    localparam logic [ADDR_W-1:0] A_PACK  = ADDR_W'(3);
    localparam logic [ADDR_W-1:0] A_MSAVE = ADDR_W'(4);
    localparam logic [ADDR_W-1:0] A_SSAVE = ADDR_W'(5);
    localparam logic [1:0]        PRV_M   = 2'd3;
    localparam logic [1:0]        PRV_S   = 2'd1;

    bank_e             cur_bank;
    wkind_e            kind;
    vlen_state_t       bank_st [NBANK];
    vlen_state_t       cur_st;
    logic [PACK_W-1:0] cur_packed;
    logic [PACK_W-1:0] save_q [2];
    logic [1:0]        save_cap;
    logic [1:0]        save_wr;

    always_comb begin
        unique case (priv_lvl)
            PRV_M:   cur_bank = BANK_M;
            PRV_S:   cur_bank = BANK_S;
            default: cur_bank = BANK_U;
        endcase
    end

    always_comb begin
        kind = WK_NONE;
        if (csr_we) begin
            unique case (csr_addr)
                A_MAX:   kind = WK_MAXLEN;
                A_CUR:   kind = WK_CURLEN;
                A_SUB:   kind = WK_SUBLEN;
                A_PACK:  kind = WK_PACKED;
                default: kind = WK_NONE;
            endcase
        end
    end

    for (genvar g = 0; g < NBANK; g++) begin : g_bank
        vlen_bank #(.XLEN(XLEN)) u_bank (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_kind ((cur_bank == bank_e'(g)) ? kind : WK_NONE),
            .wr_data (csr_wdata),
            .st_o    (bank_st[g])
        );
    end

    assign cur_st     = bank_st[cur_bank];
    assign cur_packed = pack_state(cur_st);

    assign save_cap[0] = trap_valid && (trap_priv == PRV_M);
    assign save_cap[1] = trap_valid && (trap_priv == PRV_S);
    assign save_wr[0]  = csr_we && (csr_addr == A_MSAVE);
    assign save_wr[1]  = csr_we && (csr_addr == A_SSAVE);

    for (genvar g = 0; g < 2; g++) begin : g_save
        vlen_save_reg #(.XLEN(XLEN)) u_save (
            .clk     (clk),
            .rst_n   (rst_n),
            .cap_en  (save_cap[g]),
            .cap_val (cur_packed),
            .wr_en   (save_wr[g]),
            .wr_val  (csr_wdata),
            .q       (save_q[g])
        );
    end

    always_comb begin
        unique case (csr_addr)
            A_MAX:   csr_rdata = XLEN'(cur_st.maxlen);
            A_CUR:   csr_rdata = XLEN'(cur_st.curlen);
            A_SUB:   csr_rdata = XLEN'(cur_st.sublen);
            A_PACK:  csr_rdata = XLEN'(cur_packed);
            A_MSAVE: csr_rdata = XLEN'(save_q[0]);
            A_SSAVE: csr_rdata = XLEN'(save_q[1]);
            default: csr_rdata = '0;
        endcase
    end
endmodule

// File: rtl/vlen_csr_chk.sv
module vlen_csr_chk
    import vlen_pkg::*;
#(
    parameter int XLEN   = 32,
    parameter int ADDR_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic [1:0]        priv_lvl,
    input logic              csr_we,
    input logic [ADDR_W-1:0] csr_addr,
    input logic [XLEN-1:0]   csr_rdata,
    input logic              trap_valid,
    input logic [1:0]        trap_priv,
    input vlen_state_t       bank_st [NBANK],
    input logic [PACK_W-1:0] cur_packed,
    input logic [PACK_W-1:0] save_q [2]
);
    // R3: sub-vector length of every bank stays in 1..4
    assert_sublen_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (bank_st[0].sublen >= 3'd1 && bank_st[0].sublen <= 3'd4 &&
         bank_st[1].sublen >= 3'd1 && bank_st[1].sublen <= 3'd4 &&
         bank_st[2].sublen >= 3'd1 && bank_st[2].sublen <= 3'd4));

    // R1: maximum length never exceeds the ceiling
    assert_maxlen_cap_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (bank_st[0].maxlen <= LW'(VL_MAX) && bank_st[1].maxlen <= LW'(VL_MAX) &&
         bank_st[2].maxlen <= LW'(VL_MAX)));

    // R2: a current-length write in the machine bank never exceeds its maximum
    assert_curlen_cap_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_we && csr_addr == ADDR_W'(1) && priv_lvl == 2'd3)
        |=> (bank_st[2].curlen <= bank_st[2].maxlen));

    // R5: offsets after a packed write stay below the new current length
    assert_offs_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_we && csr_addr == ADDR_W'(3) && priv_lvl == 2'd3)
        |=> ({1'b0, bank_st[2].src_off} < bank_st[2].curlen &&
             {1'b0, bank_st[2].dst_off} < bank_st[2].curlen &&
             {1'b0, bank_st[2].sub_off} < bank_st[2].sublen));

    // R7: a trap to machine level captures the packed word of the active bank
    assert_trap_msave_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_valid && trap_priv == 2'd3) |=> (save_q[0] == $past(cur_packed)));

    // R7: a trap to a non-saving level leaves both save registers alone
    assert_trap_nosave_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_valid && (trap_priv == 2'd0 || trap_priv == 2'd2) && !csr_we)
        |=> ($stable(save_q[0]) && $stable(save_q[1])));

    // R9: unimplemented addresses read zero
    assert_unimpl_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_addr > ADDR_W'(5)) |-> (csr_rdata == '0));
endmodule

bind vlen_csr_top vlen_csr_chk #(.XLEN(XLEN), .ADDR_W(ADDR_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .priv_lvl   (priv_lvl),
    .csr_we     (csr_we),
    .csr_addr   (csr_addr),
    .csr_rdata  (csr_rdata),
    .trap_valid (trap_valid),
    .trap_priv  (trap_priv),
    .bank_st    (bank_st),
    .cur_packed (cur_packed),
    .save_q     (save_q)
);

// File: tb/vlen_csr_top_tb.sv
module vlen_csr_top_tb;
    typedef struct {
        logic [31:0] exp;
        string       tag;
    } item_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  priv_lvl = 2'd3;
    logic        csr_we = 1'b0;
    logic [3:0]  csr_addr = 4'd0;
    logic [31:0] csr_wdata = 32'd0;
    logic [31:0] csr_rdata;
    logic        trap_valid = 1'b0;
    logic [1:0]  trap_priv = 2'd0;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;
    item_t q[$];

    int m_max [3];
    int m_cur [3];
    int m_sub [3];
    int m_src [3];
    int m_dst [3];
    int m_dsv [3];
    logic [31:0] m_save [2];

    always #10 clk = ~clk;

    vlen_csr_top u_dut (
        .clk(clk), .rst_n(rst_n), .priv_lvl(priv_lvl), .csr_we(csr_we),
        .csr_addr(csr_addr), .csr_wdata(csr_wdata), .csr_rdata(csr_rdata),
        .trap_valid(trap_valid), .trap_priv(trap_priv)
    );

    function automatic int bi(input logic [1:0] p);
        if (p == 2'd3) return 2;
        if (p == 2'd1) return 1;
        return 0;
    endfunction

    function automatic logic [31:0] pk(input int b);
        logic [31:0] r;
        r = 32'd0;
        r[5:0]   = (m_cur[b] == 0) ? 6'd0 : 6'(m_cur[b] - 1);
        r[11:6]  = (m_max[b] == 0) ? 6'd0 : 6'(m_max[b] - 1);
        r[17:12] = 6'(m_src[b]);
        r[23:18] = 6'(m_dst[b]);
        r[25:24] = 2'(m_sub[b] - 1);
        r[27:26] = 2'(m_dsv[b]);
        return r;
    endfunction

    function automatic int imin(input int a, input int c);
        return (a < c) ? a : c;
    endfunction

    task automatic model_write(input logic [3:0] a, input logic [31:0] d);
        int b;
        b = bi(priv_lvl);
        case (a)
            4'd0: m_max[b] = (d >= 32'd64) ? 64 : int'(d) + 1;
            4'd1: m_cur[b] = (d >= 32'(m_max[b])) ? m_max[b] : int'(d) + 1;
            4'd2: m_sub[b] = (d == 0) ? 1 : ((d >= 32'd4) ? 4 : int'(d));
            4'd3: begin
                m_max[b] = int'(d[11:6]) + 1;
                m_cur[b] = imin(m_max[b], int'(d[5:0]) + 1);
                m_sub[b] = int'(d[25:24]) + 1;
                m_src[b] = imin(int'(d[17:12]), m_cur[b] - 1);
                m_dst[b] = imin(int'(d[23:18]), m_cur[b] - 1);
                m_dsv[b] = imin(int'(d[27:26]), m_sub[b] - 1);
            end
            4'd4: m_save[0] = {4'd0, d[27:0]};
            4'd5: m_save[1] = {4'd0, d[27:0]};
            default: ;
        endcase
    endtask

    task automatic wr(input logic [1:0] p, input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        priv_lvl = p; csr_we = 1'b1; csr_addr = a; csr_wdata = d; trap_valid = 1'b0;
        model_write(a, d);
    endtask

    task automatic trap(input logic [1:0] p, input logic [1:0] to, input bit with_wr,
                        input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        priv_lvl = p; trap_valid = 1'b1; trap_priv = to;
        csr_we = with_wr; csr_addr = a; csr_wdata = d;
        if (with_wr) model_write(a, d);
        if (to == 2'd3) m_save[0] = pk(bi(p));
        if (to == 2'd1) m_save[1] = pk(bi(p));
    endtask

    task automatic chk(input logic [1:0] p, input logic [3:0] a, input logic [31:0] e,
                       input string tag);
        item_t it;
        @(negedge clk);
        priv_lvl = p; csr_we = 1'b0; csr_addr = a; trap_valid = 1'b0;
        it.exp = e; it.tag = tag;
        q.push_back(it);
    endtask

    task automatic chk_bank(input logic [1:0] p, input string tag);
        int b;
        b = bi(p);
        chk(p, 4'd0, 32'(m_max[b]), tag);
        chk(p, 4'd1, 32'(m_cur[b]), tag);
        chk(p, 4'd2, 32'(m_sub[b]), tag);
        chk(p, 4'd3, pk(b), tag);
    endtask

    initial begin : monitor
        forever begin
            @(negedge clk);
            #5;
            if (q.size() > 0) begin
                item_t it;
                it = q.pop_front();
                n_chk++;
                if (csr_rdata !== it.exp) begin
                    n_bad++;
                    $display("FAIL %s: got %h expected %h", it.tag, csr_rdata, it.exp);
                end
            end
        end
    end

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin : driver
        for (int i = 0; i < 3; i++) begin
            m_max[i] = 0; m_cur[i] = 0; m_sub[i] = 1;
            m_src[i] = 0; m_dst[i] = 0; m_dsv[i] = 0;
        end
        m_save[0] = 0; m_save[1] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R6: reset state in every bank and the save registers
        chk_bank(2'd3, "R6 reset M");
        chk_bank(2'd1, "R6 reset S");
        chk_bank(2'd0, "R6 reset U");
        chk(2'd3, 4'd4, 32'd0, "R6 reset msave");
        chk(2'd3, 4'd5, 32'd0, "R6 reset ssave");

        // R1: maximum length encoding and cap
        wr(2'd3, 4'd0, 32'd9);          chk(2'd3, 4'd0, 32'd10, "R1 max 9");
        wr(2'd3, 4'd0, 32'd63);         chk(2'd3, 4'd0, 32'd64, "R1 max 63");
        wr(2'd3, 4'd0, 32'd100);        chk(2'd3, 4'd0, 32'd64, "R1 max 100");
        wr(2'd3, 4'd0, 32'hFFFF_FFFF);  chk(2'd3, 4'd0, 32'd64, "R1 max all ones");

        // R2: current length against maximum
        wr(2'd3, 4'd1, 32'd5);          chk(2'd3, 4'd1, 32'd6, "R2 cur 5");
        wr(2'd3, 4'd1, 32'd200);        chk(2'd3, 4'd1, 32'd64, "R2 cur 200");
        wr(2'd3, 4'd0, 32'd9);
        wr(2'd3, 4'd1, 32'd20);         chk(2'd3, 4'd1, 32'd10, "R2 cur clamp");
        wr(2'd3, 4'd1, 32'd9);          chk(2'd3, 4'd1, 32'd10, "R2 cur equal");

        // R3: sub-vector length range
        wr(2'd3, 4'd2, 32'd0);          chk(2'd3, 4'd2, 32'd1, "R3 sub 0");
        wr(2'd3, 4'd2, 32'd3);          chk(2'd3, 4'd2, 32'd3, "R3 sub 3");
        wr(2'd3, 4'd2, 32'd7);          chk(2'd3, 4'd2, 32'd4, "R3 sub 7");

        // R4: packed read layout after field writes
        chk(2'd3, 4'd3, pk(2), "R4 packed layout");
        chk(2'd3, 4'd3, 32'h0300_0249, "R4 packed literal");

        // R5: packed write, new maximum first, offsets clamped
        wr(2'd3, 4'd3, {4'd0, 2'd3, 2'd1, 6'd3, 6'd50, 6'd9, 6'd20});
        chk(2'd3, 4'd1, 32'd10, "R5 cur vs new max");
        chk(2'd3, 4'd0, 32'd10, "R5 max");
        chk(2'd3, 4'd2, 32'd2, "R5 sub");
        chk(2'd3, 4'd3, {4'd0, 2'd1, 2'd1, 6'd3, 6'd9, 6'd9, 6'd9}, "R5 packed back");
        wr(2'd3, 4'd3, {4'd0, 2'd0, 2'd0, 6'd0, 6'd0, 6'd40, 6'd40});
        chk(2'd3, 4'd3, {4'd0, 2'd0, 2'd0, 6'd0, 6'd0, 6'd40, 6'd40}, "R5 grow max first");

        // R8: bank selection and isolation
        wr(2'd1, 4'd0, 32'd3);
        wr(2'd2, 4'd0, 32'd7);
        wr(2'd0, 4'd1, 32'd2);
        chk_bank(2'd3, "R8 M unchanged");
        chk_bank(2'd1, "R8 S bank");
        chk_bank(2'd0, "R8 U via priv 2");
        chk(2'd2, 4'd1, 32'd3, "R8 priv 2 aliases U");

        // R9: unimplemented addresses
        wr(2'd3, 4'd6, 32'hFFFF_FFFF);
        wr(2'd3, 4'd15, 32'd1);
        chk(2'd3, 4'd6, 32'd0, "R9 read 6");
        chk(2'd3, 4'd15, 32'd0, "R9 read 15");
        chk_bank(2'd3, "R9 M untouched");

        // R10: save registers through CSR port
        wr(2'd3, 4'd4, 32'hFABC_1234);  chk(2'd3, 4'd4, 32'h0ABC_1234, "R10 msave wr");
        wr(2'd1, 4'd5, 32'h1234_5678);  chk(2'd1, 4'd5, 32'h0234_5678, "R10 ssave wr");

        // R7: trap capture
        trap(2'd0, 2'd3, 1'b0, 4'd0, 32'd0);
        chk(2'd3, 4'd4, m_save[0], "R7 trap to M from U");
        trap(2'd3, 2'd1, 1'b0, 4'd0, 32'd0);
        chk(2'd3, 4'd5, m_save[1], "R7 trap to S from M");
        trap(2'd1, 2'd0, 1'b0, 4'd0, 32'd0);
        trap(2'd1, 2'd2, 1'b0, 4'd0, 32'd0);
        chk(2'd3, 4'd4, m_save[0], "R7 no-save level msave");
        chk(2'd3, 4'd5, m_save[1], "R7 no-save level ssave");

        // R10: trap capture wins over a same-cycle CSR write
        trap(2'd1, 2'd3, 1'b1, 4'd4, 32'h0000_0001);
        chk(2'd3, 4'd4, pk(1), "R10 capture wins");

        repeat (2) @(negedge clk);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule